// File: doc/BRIEF.md
# Bus Master Security Gate

This block sits on the path from a single bus master to a downstream memory-mapped bus and decides, per transaction, whether the access may pass and with which security marking. When a request is accepted, the gate presents its address to an external address-attribution lookup. The lookup answers with two flags: one saying the address is exempt from checking, and one saying the address lies in a non-secure region. The gate combines these flags with the master's configured security level and picks one of four outcomes:

- forward the access marked secure,
- forward it marked non-secure,
- complete it locally as read-as-zero/write-ignored,
- complete it locally with an error response.

A local error-type block raises a sticky, level interrupt. A clear input wipes the interrupt while it is held high, and the same input also stops a block from raising it. Only one transaction is in flight at a time. The downstream request appears one cycle after the master's request is accepted.

Top module: `mstr_sec_gate`

## Requirements
- R1: If the lookup reports the address exempt, the access is forwarded, with `d_req_secure` low when `cfg_master_ns` is high and high when it is low.
- R2: If the address is not exempt and the lookup reports it non-secure, the access is forwarded with `d_req_secure` low, whatever the master configuration.
- R3: A non-exempt secure address accessed with `cfg_master_ns` low is forwarded with `d_req_secure` high.
- R4: A non-exempt secure address accessed with `cfg_master_ns` high and `cfg_block_err` low is completed locally. The response has `m_rsp_err` low and `m_rsp_rdata` zero, and no downstream request is made.
- R5: The same blocked access with `cfg_block_err` high completes locally with `m_rsp_err` high and raises no downstream request.
- R6: An error-type block sets the interrupt status (visible on `irq_o` the cycle after acceptance) unless `irq_clr` is high when the request is accepted.
- R7: While `irq_clr` is high the interrupt status is cleared on the next edge. Once set, the status stays set until then. A read-as-zero block never sets it.
- R8: The downstream request asserts the cycle after acceptance and is held, with stable fields, until `d_req_ready`. Its address, write flag and write data equal the master's.
- R9: For a forwarded access the downstream error flag and read data return unchanged on the master side. `m_rsp_valid` is a one-cycle pulse the cycle after `d_rsp_valid`.
- R10: Only one transaction is outstanding. `m_req_ready` is low from the cycle after acceptance until the response cycle has passed.
- R11: After reset the gate is idle: `m_req_ready` high, `d_req_valid`, `m_rsp_valid` and `irq_o` low.
- R12: The size code (0=1, 1=2, 2=4, 3=8 bytes, little-endian) is passed downstream unchanged. `lk_addr` always equals `m_req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master_ns | input | 1 | Master is non-secure when high |
| cfg_block_err | input | 1 | Blocked accesses error when high, read-as-zero when low |
| irq_clr | input | 1 | Interrupt clear and suppress, level |
| irq_o | output | 1 | Sticky interrupt level |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Gate can accept a request |
| m_req_write | input | 1 | Request is a write |
| m_req_size | input | 2 | Access size code |
| m_req_addr | input | AW | Request address |
| m_req_wdata | input | DW | Write data |
| m_rsp_valid | output | 1 | Response pulse to master |
| m_rsp_err | output | 1 | Response is an error |
| m_rsp_rdata | output | DW | Read data to master |
| lk_addr | output | AW | Address presented to the lookup |
| lk_exempt | input | 1 | Lookup: address exempt from checking |
| lk_nonsec | input | 1 | Lookup: address is non-secure |
| d_req_valid | output | 1 | Downstream request valid |
| d_req_ready | input | 1 | Downstream accepts request |
| d_req_write | output | 1 | Downstream write flag |
| d_req_size | output | 2 | Downstream size code |
| d_req_addr | output | AW | Downstream address |
| d_req_wdata | output | DW | Downstream write data |
| d_req_secure | output | 1 | Security marking of forwarded access |
| d_rsp_valid | input | 1 | Downstream response valid |
| d_rsp_err | input | 1 | Downstream response error |
| d_rsp_rdata | input | DW | Downstream read data |

## Verification
The decision is driven through all sixteen combinations of exempt flag, region flag, master level and block mode. This separates each outcome from its neighbours: exemption against region security, and a secure master against a non-secure one. Across the vectors the sizes, write direction and downstream error flag vary, so pass-through faults show up as field mismatches. Directed cases then hold `irq_clr` through an error block to tell suppression apart from ordinary setting. They place a silent block after a set interrupt to show it leaves the status alone, and they stall `d_req_ready` to show the request holds.

// File: rtl/gate_pkg.sv
package gate_pkg;

    typedef enum logic [1:0] {
        V_FWD_SEC  = 2'd0,
        V_FWD_NS   = 2'd1,
        V_BLK_ZERO = 2'd2,
        V_BLK_ERR  = 2'd3
    } verdict_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2,
        PH_REPLY = 2'd3
    } phase_e;

endpackage

// File: rtl/gate_verdict.sv
module gate_verdict
    import gate_pkg::*;
(
    input  logic     exempt,
    input  logic     region_ns,
    input  logic     master_ns,
    input  logic     err_mode,
    output verdict_e verdict
);

    always_comb begin
        if (exempt) begin
            verdict = master_ns ? V_FWD_NS : V_FWD_SEC;
        end else if (region_ns) begin
            verdict = V_FWD_NS;
        end else if (!master_ns) begin
            verdict = V_FWD_SEC;
        end else begin
            verdict = err_mode ? V_BLK_ERR : V_BLK_ZERO;
        end
    end

endmodule

// File: rtl/gate_irq.sv
module gate_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_lvl,
    output logic flag
);

    logic flag_d, flag_q;

    always_comb begin
        // clear dominates, which also suppresses a set in the same cycle
        flag_d = clr_lvl ? 1'b0 : (flag_q | set_evt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

endmodule

// File: rtl/mstr_sec_gate.sv
module mstr_sec_gate
    import gate_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_master_ns,
    input  logic          cfg_block_err,
    input  logic          irq_clr,
    output logic          irq_o,
    input  logic          m_req_valid,
    output logic          m_req_ready,
    input  logic          m_req_write,
    input  logic [1:0]    m_req_size,
    input  logic [AW-1:0] m_req_addr,
    input  logic [DW-1:0] m_req_wdata,
    output logic          m_rsp_valid,
    output logic          m_rsp_err,
    output logic [DW-1:0] m_rsp_rdata,
    output logic [AW-1:0] lk_addr,
    input  logic          lk_exempt,
    input  logic          lk_nonsec,
    output logic          d_req_valid,
    input  logic          d_req_ready,
    output logic          d_req_write,
    output logic [1:0]    d_req_size,
    output logic [AW-1:0] d_req_addr,
    output logic [DW-1:0] d_req_wdata,
    output logic          d_req_secure,
    input  logic          d_rsp_valid,
    input  logic          d_rsp_err,
    input  logic [DW-1:0] d_rsp_rdata
);

    typedef struct packed {
        phase_e        ph;
        logic [AW-1:0] addr;
        logic [1:0]    size;
        logic          wr;
        logic [DW-1:0] wdata;
        logic          sec;
        logic          err;
        logic [DW-1:0] rdata;
    } gate_st_t;

    gate_st_t st_d, st_q;
    verdict_e verdict;
    logic     accept;

    assign lk_addr = m_req_addr;
    assign accept  = (st_q.ph == PH_IDLE) && m_req_valid;

    gate_verdict u_verdict (
        .exempt    (lk_exempt),
        .region_ns (lk_nonsec),
        .master_ns (cfg_master_ns),
        .err_mode  (cfg_block_err),
        .verdict   (verdict)
    );

    gate_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (accept && (verdict == V_BLK_ERR)),
        .clr_lvl (irq_clr),
        .flag    (irq_o)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (accept) begin
                    st_d.addr  = m_req_addr;
                    st_d.size  = m_req_size;
                    st_d.wr    = m_req_write;
                    st_d.wdata = m_req_wdata;
                    st_d.sec   = (verdict == V_FWD_SEC);
                    st_d.rdata = '0;
                    st_d.err   = (verdict == V_BLK_ERR);
                    if (verdict == V_FWD_SEC || verdict == V_FWD_NS) st_d.ph = PH_ISSUE;
                    else                                             st_d.ph = PH_REPLY;
                end
            end
            PH_ISSUE: begin
                if (d_req_ready) st_d.ph = PH_WAIT;
            end
            PH_WAIT: begin
                if (d_rsp_valid) begin
                    st_d.err   = d_rsp_err;
                    st_d.rdata = d_rsp_rdata;
                    st_d.ph    = PH_REPLY;
                end
            end
            PH_REPLY: begin
                st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_req_ready  = (st_q.ph == PH_IDLE);
    assign d_req_valid  = (st_q.ph == PH_ISSUE);
    assign d_req_write  = st_q.wr;
    assign d_req_size   = st_q.size;
    assign d_req_addr   = st_q.addr;
    assign d_req_wdata  = st_q.wdata;
    assign d_req_secure = st_q.sec;
    assign m_rsp_valid  = (st_q.ph == PH_REPLY);
    assign m_rsp_err    = st_q.err;
    assign m_rsp_rdata  = st_q.rdata;

endmodule

// File: rtl/gate_checker.sv
module gate_checker #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_master_ns,
    input logic          cfg_block_err,
    input logic          irq_clr,
    input logic          irq_o,
    input logic          m_req_valid,
    input logic          m_req_ready,
    input logic          m_rsp_valid,
    input logic          m_rsp_err,
    input logic [DW-1:0] m_rsp_rdata,
    input logic          lk_exempt,
    input logic          lk_nonsec,
    input logic          d_req_valid,
    input logic          d_req_ready,
    input logic [AW-1:0] d_req_addr,
    input logic          d_rsp_valid,
    input logic          d_rsp_err
);

    logic acc, blocked;
    assign acc     = m_req_valid && m_req_ready;
    assign blocked = acc && cfg_master_ns && !lk_exempt && !lk_nonsec;

    assert_blk_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !cfg_block_err) |=> (m_rsp_valid && !d_req_valid && !m_rsp_err && m_rsp_rdata == '0));

    assert_blk_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && cfg_block_err) |=> (m_rsp_valid && !d_req_valid && m_rsp_err));

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(blocked && cfg_block_err && !irq_clr));

    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq_o);

    assert_zero_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !cfg_block_err && !irq_o) |=> !irq_o);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req_valid && !d_req_ready) |=> (d_req_valid && $stable(d_req_addr)));

    assert_rsp_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_rsp_valid && !d_req_valid && !m_rsp_valid && !m_req_ready)
            |=> (m_rsp_valid && m_rsp_err == $past(d_rsp_err)));

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_rsp_valid |=> !m_rsp_valid);

    assert_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !m_req_ready);

endmodule

bind mstr_sec_gate gate_checker #(.AW(AW), .DW(DW)) u_gate_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_master_ns (cfg_master_ns),
    .cfg_block_err (cfg_block_err),
    .irq_clr       (irq_clr),
    .irq_o         (irq_o),
    .m_req_valid   (m_req_valid),
    .m_req_ready   (m_req_ready),
    .m_rsp_valid   (m_rsp_valid),
    .m_rsp_err     (m_rsp_err),
    .m_rsp_rdata   (m_rsp_rdata),
    .lk_exempt     (lk_exempt),
    .lk_nonsec     (lk_nonsec),
    .d_req_valid   (d_req_valid),
    .d_req_ready   (d_req_ready),
    .d_req_addr    (d_req_addr),
    .d_rsp_valid   (d_rsp_valid),
    .d_rsp_err     (d_rsp_err)
);

// File: tb/mstr_sec_gate_bench.sv
module mstr_sec_gate_bench;

    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_master_ns = 1'b0, cfg_block_err = 1'b0, irq_clr = 1'b0;
    logic          irq_o;
    logic          m_req_valid = 1'b0, m_req_ready, m_req_write = 1'b0;
    logic [1:0]    m_req_size = '0;
    logic [AW-1:0] m_req_addr = '0;
    logic [DW-1:0] m_req_wdata = '0;
    logic          m_rsp_valid, m_rsp_err;
    logic [DW-1:0] m_rsp_rdata;
    logic [AW-1:0] lk_addr;
    logic          lk_exempt = 1'b0, lk_nonsec = 1'b0;
    logic          d_req_valid, d_req_ready = 1'b1, d_req_write, d_req_secure;
    logic [1:0]    d_req_size;
    logic [AW-1:0] d_req_addr;
    logic [DW-1:0] d_req_wdata;
    logic          d_rsp_valid = 1'b0, d_rsp_err = 1'b0;
    logic [DW-1:0] d_rsp_rdata = '0;

    always #10 clk = ~clk;

    mstr_sec_gate #(.AW(AW), .DW(DW)) u_mstr_sec_gate (.*);

    int n_chk = 0, n_bad = 0;
    logic exp_irq = 1'b0;
    bit done = 1'b0;

    // {exempt, region_ns, master_ns, err_mode, write, expected outcome[1:0]}
    // outcome: 0 forward secure, 1 forward non-secure, 2 read-as-zero, 3 error
    localparam logic [6:0] VEC [16] = '{
        7'b0000_0_00, 7'b0001_1_00, 7'b0010_1_10, 7'b0011_0_11,
        7'b0100_1_01, 7'b0101_0_01, 7'b0110_0_01, 7'b0111_1_01,
        7'b1000_1_00, 7'b1001_0_00, 7'b1010_0_01, 7'b1011_1_01,
        7'b1100_0_00, 7'b1101_1_00, 7'b1110_1_01, 7'b1111_0_01
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a negedge with the gate idle; returns at a negedge, gate idle.
    task automatic run_txn(input logic ex, input logic lkns, input logic ns,
                           input logic em, input logic wr, input logic [1:0] sz,
                           input logic [1:0] expv, input logic ds_err,
                           input int stall, input logic [AW-1:0] adr,
                           input string tag);
        logic [DW-1:0] wd, rd;
        wd = {32'hC0DE_0000 | adr, ~adr};
        rd = {adr, 32'h5A5A_0000} ^ 64'h1;
        cfg_master_ns = ns; cfg_block_err = em;
        lk_exempt = ex; lk_nonsec = lkns;
        m_req_valid = 1'b1; m_req_write = wr; m_req_size = sz;
        m_req_addr = adr; m_req_wdata = wd;
        d_req_ready = (stall == 0);
        #1;
        chk(lk_addr == adr, "R12", "lookup address", lk_addr, adr);
        @(posedge clk);
        @(negedge clk);
        m_req_valid = 1'b0;
        if (irq_clr) exp_irq = 1'b0;
        else if (expv == 2'd3) exp_irq = 1'b1;
        chk(m_req_ready == 1'b0, "R10", "ready after accept", m_req_ready, 0);
        chk(irq_o == exp_irq, (expv == 2'd3) ? "R6" : "R7", "irq level", irq_o, exp_irq);
        if (expv[1] == 1'b0) begin
            chk(d_req_valid == 1'b1, tag, "forwarded", d_req_valid, 1);
            chk(d_req_secure == (expv == 2'd0), tag, "secure mark", d_req_secure, expv == 2'd0);
            chk({d_req_addr, d_req_write} == {adr, wr}, "R8", "addr/write", {d_req_addr, d_req_write}, {adr, wr});
            chk(d_req_wdata == wd, "R8", "wdata", d_req_wdata, wd);
            chk(d_req_size == sz, "R12", "size", d_req_size, sz);
            for (int k = 0; k < stall; k++) begin
                @(posedge clk);
                @(negedge clk);
                chk(d_req_valid && d_req_addr == adr, "R8", "held while stalled", d_req_valid, 1);
                chk(m_req_ready == 1'b0, "R10", "ready while busy", m_req_ready, 0);
            end
            d_req_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            d_rsp_valid = 1'b1; d_rsp_err = ds_err; d_rsp_rdata = rd;
            @(posedge clk);
            @(negedge clk);
            d_rsp_valid = 1'b0;
            chk(m_rsp_valid == 1'b1, "R9", "rsp valid", m_rsp_valid, 1);
            chk(m_rsp_err == ds_err, "R9", "rsp err", m_rsp_err, ds_err);
            chk(m_rsp_rdata == rd, "R9", "rsp data", m_rsp_rdata, rd);
        end else begin
            chk(d_req_valid == 1'b0, tag, "no downstream", d_req_valid, 0);
            chk(m_rsp_valid == 1'b1, tag, "local rsp", m_rsp_valid, 1);
            chk(m_rsp_err == (expv == 2'd3), tag, "local err", m_rsp_err, expv == 2'd3);
            chk(m_rsp_rdata == '0, tag, "local data", m_rsp_rdata, 0);
        end
        @(posedge clk);
        @(negedge clk);
        chk(m_rsp_valid == 1'b0 && m_req_ready == 1'b1, "R9", "rsp pulse ends", m_rsp_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(m_req_ready && !d_req_valid && !m_rsp_valid && !irq_o, "R11", "reset state",
            {m_req_ready, d_req_valid, m_rsp_valid, irq_o}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 16; i++) begin
            logic [6:0] v;
            string t;
            v = VEC[i];
            t = v[6] ? "R1" : v[5] ? "R2" : !v[4] ? "R3" : v[3] ? "R5" : "R4";
            run_txn(v[6], v[5], v[4], v[3], v[2], 2'(i), v[1:0], (i % 3) == 0, 0,
                    32'h1000_0000 + 32'(i * 8), t);
        end

        // R7: silent write block leaves a set interrupt alone and never sets one
        run_txn(0, 0, 1, 0, 1, 2'd3, 2'd2, 0, 0, 32'h2000_0040, "R4");
        irq_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        exp_irq = 1'b0;
        chk(irq_o == 1'b0, "R7", "clear", irq_o, 0);
        // R6: error block while clear held does not raise the interrupt
        run_txn(0, 0, 1, 1, 1, 2'd2, 2'd3, 0, 0, 32'h2000_0080, "R5");
        irq_clr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(irq_o == 1'b0, "R6", "suppressed", irq_o, 0);
        run_txn(0, 0, 1, 0, 0, 2'd1, 2'd2, 0, 0, 32'h2000_00C0, "R4");
        chk(irq_o == 1'b0, "R7", "zero block no set", irq_o, 0);
        // R8: downstream stall
        run_txn(0, 1, 1, 1, 1, 2'd3, 2'd1, 1, 3, 32'h3000_0100, "R2");
        // R6: error block sets and stays
        run_txn(0, 0, 1, 1, 0, 2'd0, 2'd3, 0, 0, 32'h3000_0140, "R5");
        repeat (3) @(negedge clk);
        chk(irq_o == 1'b1, "R7", "sticky", irq_o, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule